// File: doc/BRIEF.md
# Flow-Controlled Serial Receive Buffer

This block holds bytes from a UART receiver until a host reads them. Storage is a 256-entry ring addressed by an 8-bit write pointer and an 8-bit read pointer. The ring is empty when the two pointers are equal. It accepts at most 255 bytes. The host sees the oldest byte and a valid flag in the same cycle as its read strobe. A read strobe on an empty ring reports no data and moves neither pointer.

Toward the remote sender the block drives a registered stop request, `stop_req`. This is the line usually called RTS, and it is high when the sender must pause. The request is raised when a write leaves the ring with 240 or more bytes. It is lowered only when a read leaves fewer than 128 bytes. Software can hold the request high with a force input.

The block also watches the peer's CTS line and produces a registered transmit enable for the local transmitter. The stop request never affects that enable. A write that arrives while 255 bytes are stored is discarded, and this raises a sticky overrun flag. A dedicated input clears the flag.

Top module: `rxflow_buffer`

## Requirements
- R1: After reset the stop request is low, the overrun flag is low, the transmit enable is low and the ring is empty, so a read strobe gives `rd_valid` low.
- R2: Bytes are returned in the order they were written, including after both pointers pass through 255 back to 0.
- R3: A read strobe while the ring is empty drives `rd_valid` low in that cycle and does not advance the read pointer. The next stored byte is still the one returned by the next successful read.
- R4: When an accepted write leaves the fill level (write pointer minus read pointer, modulo 256) at 240 or more, `stop_req` is high from the next cycle.
- R5: A high `stop_req` is lowered only by a successful read that leaves the fill level below 128. It goes low one cycle after that read.
- R6: While `force_stop` is high, `stop_req` is high from the next cycle and cannot be released by any read.
- R7: `tx_en` equals the inverse of `peer_cts`, delayed by one register stage: CTS high disables and CTS low enables. It is unaffected by `stop_req` and by the fill level.
- R8: A write strobe while 255 bytes are stored is discarded and sets `overrun` from the next cycle. `overrun` stays high until a cycle with `overrun_clr` high and no new overrun, and a new overrun wins over a clear in the same cycle.
- R9: A write and a successful read in the same cycle are both performed. The stop thresholds are applied to the fill level that results from both.
- R10: On a successful read, `rd_data` carries the byte at the read pointer in the same cycle as `rd_req`.

Default thresholds: `STOP_ON_LVL` = 240 and `GO_BELOW_LVL` = 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_strobe | input | 1 | One received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Host read strobe |
| rd_data | output | 8 | Oldest stored byte (combinational) |
| rd_valid | output | 1 | High when `rd_req` is honoured in this cycle |
| force_stop | input | 1 | Software hold of the stop request |
| overrun_clr | input | 1 | Clears the sticky overrun flag |
| peer_cts | input | 1 | Peer's clear-to-send, high means stop transmitting |
| stop_req | output | 1 | Registered stop request toward the remote sender (RTS) |
| tx_en | output | 1 | Registered transmit enable for the local transmitter |
| overrun | output | 1 | Sticky flag for a discarded write |

## Verification
`rd_valid` and `rd_data` are combinational. The bench therefore checks them in the same cycle as `rd_req`, one time unit after it drives the inputs on the falling edge. `stop_req`, `overrun` and `tx_en` each pass through one register. The bench checks them on the falling edge after the rising edge that captured the stimulus. Its queue-based model advances at that point, so every output is compared with the model each cycle at the latency it is due. The stimulus covers both threshold crossings and the full-ring drop with a clear in the same cycle. It also covers a forced hold through a complete drain, simultaneous write and read, and CTS toggling while the stop request is high.

// File: rtl/rxflow_pkg.sv
package rxflow_pkg;

    // Events decided in one cycle by the control logic
    typedef struct packed {
        logic wr_acc;
        logic rd_acc;
        logic set_stop;
        logic drop_stop;
        logic new_ovr;
    } flow_ev_t;

    localparam flow_ev_t FLOW_EV_NONE = '{default: 1'b0};

endpackage

// File: rtl/rxflow_ring.sv
module rxflow_ring #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells_q[rd_addr];
endmodule

// File: rtl/rxflow_txgate.sv
module rxflow_txgate #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_in,
    output logic tx_en
);
    generate
        if (STAGES <= 1) begin : g_single
            logic en_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) en_q <= 1'b0;
                else        en_q <= ~cts_in;
            end
            assign tx_en = en_q;
        end else begin : g_chain
            logic [STAGES-1:0] en_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) en_q <= '0;
                else        en_q <= {en_q[STAGES-2:0], ~cts_in};
            end
            assign tx_en = en_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rxflow_ctrl.sv
module rxflow_ctrl
    import rxflow_pkg::*;
#(
    parameter int PTR_W        = 8,
    parameter int STOP_ON_LVL  = 240,
    parameter int GO_BELOW_LVL = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_strobe,
    input  logic             rd_req,
    input  logic             force_stop,
    input  logic             overrun_clr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             wr_en,
    output logic             rd_ok,
    output logic [PTR_W-1:0] fill,
    output logic             stop_req,
    output logic             overrun
);
    localparam logic [PTR_W-1:0] HI_L = PTR_W'(STOP_ON_LVL);
    localparam logic [PTR_W-1:0] LO_L = PTR_W'(GO_BELOW_LVL);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic             stop;
        logic             ovr;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    flow_ev_t         ev_d;
    logic [PTR_W-1:0] fill_d;
    logic [PTR_W-1:0] next_fill_d;
    logic             empty_d, full_d;

    always_comb begin
        fill_d      = st_q.wr_ptr - st_q.rd_ptr;
        empty_d     = (fill_d == '0);
        full_d      = (fill_d == '1);

        ev_d        = FLOW_EV_NONE;
        ev_d.wr_acc = rx_strobe & ~full_d;
        ev_d.rd_acc = rd_req & ~empty_d;
        ev_d.new_ovr = rx_strobe & full_d;

        next_fill_d = fill_d + PTR_W'(ev_d.wr_acc) - PTR_W'(ev_d.rd_acc);

        ev_d.set_stop  = force_stop | (ev_d.wr_acc & (next_fill_d >= HI_L));
        ev_d.drop_stop = ev_d.rd_acc & (next_fill_d < LO_L) & ~force_stop;

        st_d = st_q;
        if (ev_d.wr_acc) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (ev_d.rd_acc) st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        st_d.stop = ev_d.set_stop | (st_q.stop & ~ev_d.drop_stop);
        st_d.ovr  = ev_d.new_ovr  | (st_q.ovr & ~overrun_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr   = st_q.wr_ptr;
    assign rd_ptr   = st_q.rd_ptr;
    assign wr_en    = ev_d.wr_acc;
    assign rd_ok    = ev_d.rd_acc;
    assign fill     = fill_d;
    assign stop_req = st_q.stop;
    assign overrun  = st_q.ovr;
endmodule

// File: rtl/rxflow_buffer.sv
module rxflow_buffer #(
    parameter int DATA_W       = 8,
    parameter int PTR_W        = 8,
    parameter int STOP_ON_LVL  = 240,
    parameter int GO_BELOW_LVL = 128,
    parameter int CTS_STAGES   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              force_stop,
    input  logic              overrun_clr,
    input  logic              peer_cts,
    output logic              stop_req,
    output logic              tx_en,
    output logic              overrun
);
    logic [PTR_W-1:0] wr_ptr_w, rd_ptr_w, fill_lvl;
    logic             wr_en_w;

    rxflow_ctrl #(
        .PTR_W       (PTR_W),
        .STOP_ON_LVL (STOP_ON_LVL),
        .GO_BELOW_LVL(GO_BELOW_LVL)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_strobe  (rx_strobe),
        .rd_req     (rd_req),
        .force_stop (force_stop),
        .overrun_clr(overrun_clr),
        .wr_ptr     (wr_ptr_w),
        .rd_ptr     (rd_ptr_w),
        .wr_en      (wr_en_w),
        .rd_ok      (rd_valid),
        .fill       (fill_lvl),
        .stop_req   (stop_req),
        .overrun    (overrun)
    );

    rxflow_ring #(
        .DATA_W(DATA_W),
        .ADDR_W(PTR_W)
    ) ring_i (
        .clk    (clk),
        .wr_en  (wr_en_w),
        .wr_addr(wr_ptr_w),
        .wr_data(rx_byte),
        .rd_addr(rd_ptr_w),
        .rd_data(rd_data)
    );

    rxflow_txgate #(
        .STAGES(CTS_STAGES)
    ) txgate_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cts_in(peer_cts),
        .tx_en (tx_en)
    );
endmodule

// File: rtl/rxflow_buffer_chk.sv
module rxflow_buffer_chk #(
    parameter int PTR_W        = 8,
    parameter int STOP_ON_LVL  = 240,
    parameter int GO_BELOW_LVL = 128,
    parameter int CTS_STAGES   = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_strobe,
    input logic             rd_req,
    input logic             rd_valid,
    input logic             force_stop,
    input logic             overrun_clr,
    input logic             peer_cts,
    input logic             stop_req,
    input logic             tx_en,
    input logic             overrun,
    input logic [PTR_W-1:0] fill
);
    localparam logic [PTR_W-1:0] HI_M1 = PTR_W'(STOP_ON_LVL - 1);
    localparam logic [PTR_W-1:0] LO_L  = PTR_W'(GO_BELOW_LVL);

    // R3: empty ring never reports valid data
    a_r3_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fill == '0) |-> !rd_valid);

    // R4: write reaching the high level raises the stop request
    a_r4_stop_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !rd_req && fill == HI_M1) |=> stop_req);

    // R5: no release while the level stays at or above the low mark
    a_r5_hold_above_low: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && fill > LO_L) |=> stop_req);

    // R6: forced hold keeps the stop request high
    a_r6_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop |=> stop_req);

    // R8: write into a full ring sets the sticky overrun flag
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && fill == '1) |=> overrun);

    // R8: flag persists without a clear
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !overrun_clr) |=> overrun);

    generate
        if (CTS_STAGES <= 1) begin : g_cts1
            // R7: transmit enable follows inverted CTS after one stage
            a_r7_tx_follows_cts: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (tx_en == !$past(peer_cts)));
        end
    endgenerate
endmodule

bind rxflow_buffer rxflow_buffer_chk #(
    .PTR_W       (PTR_W),
    .STOP_ON_LVL (STOP_ON_LVL),
    .GO_BELOW_LVL(GO_BELOW_LVL),
    .CTS_STAGES  (CTS_STAGES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_strobe  (rx_strobe),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .force_stop (force_stop),
    .overrun_clr(overrun_clr),
    .peer_cts   (peer_cts),
    .stop_req   (stop_req),
    .tx_en      (tx_en),
    .overrun    (overrun),
    .fill       (fill_lvl)
);

// File: tb/rxflow_buffer_tb_top.sv
`timescale 1ns/1ps
module rxflow_buffer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_strobe, rd_req, force_stop, overrun_clr, peer_cts;
    logic [7:0] rx_byte, rd_data;
    logic       rd_valid, stop_req, tx_en, overrun;

    always #4 clk = ~clk;   // 125 MHz

    rxflow_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .force_stop(force_stop), .overrun_clr(overrun_clr), .peer_cts(peer_cts),
        .stop_req(stop_req), .tx_en(tx_en), .overrun(overrun)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] mq[$];
    bit         m_stop, m_ovr, m_tx;
    bit         f_force, f_cts;
    int         seq = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, check, then advance the model
    task automatic cyc(input bit w, input logic [7:0] d, input bit r, input bit clr,
                       input string tag);
        int  sz, nsz;
        bit  wacc, racc;
        @(negedge clk);
        rx_strobe = w; rx_byte = d; rd_req = r; overrun_clr = clr;
        force_stop = f_force; peer_cts = f_cts;
        #1;
        sz = mq.size();
        chk({tag, " stop_req"}, 32'(stop_req), 32'(m_stop));
        chk("R7 tx_en", 32'(tx_en), 32'(m_tx));
        chk("R8 overrun", 32'(overrun), 32'(m_ovr));
        if (r) begin
            chk("R3 rd_valid", 32'(rd_valid), 32'(sz > 0));
            if (sz > 0) chk("R2/R10 rd_data", 32'(rd_data), 32'(mq[0]));
        end
        wacc = w && sz < 255;
        racc = r && sz > 0;
        if (w && sz == 255) m_ovr = 1'b1;
        else if (clr)       m_ovr = 1'b0;
        if (racc) void'(mq.pop_front());
        if (wacc) mq.push_back(d);
        nsz = mq.size();
        if (f_force || (wacc && nsz >= 240)) m_stop = 1'b1;
        else if (racc && nsz < 128)          m_stop = 1'b0;
        m_tx = !f_cts;
    endtask

    task automatic wr(input string tag);
        seq++;
        cyc(1'b1, 8'(seq * 7 + 3), 1'b0, 1'b0, tag);
    endtask
    task automatic rd(input string tag);
        cyc(1'b0, 8'h00, 1'b1, 1'b0, tag);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; rx_strobe = 0; rx_byte = 0; rd_req = 0;
        force_stop = 0; overrun_clr = 0; peer_cts = 1'b1;
        f_force = 0; f_cts = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; rd_req = 1'b1;
        #1;
        // R1: reset state
        chk("R1 stop_req", 32'(stop_req), 0);
        chk("R1 overrun", 32'(overrun), 0);
        chk("R1 tx_en", 32'(tx_en), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        rd_req = 1'b0;
        m_stop = 0; m_ovr = 0; m_tx = !f_cts;

        // R3: empty reads, then a few bytes interleaved with empty reads
        rd("R3"); rd("R3");
        for (int i = 0; i < 5; i++) wr("R2");
        for (int i = 0; i < 7; i++) rd("R3");
        wr("R10"); rd("R10"); rd("R3"); wr("R10"); rd("R10");

        // R4: fill to the high level
        for (int i = 0; i < 239; i++) wr("R4");
        wr("R4"); cyc(1'b0, 8'h0, 1'b0, 1'b0, "R4");
        // R7: CTS toggles while stop request is high
        f_cts = 1'b0; cyc(1'b0, 8'h0, 1'b0, 1'b0, "R7");
        cyc(1'b0, 8'h0, 1'b0, 1'b0, "R7");
        f_cts = 1'b1; cyc(1'b0, 8'h0, 1'b0, 1'b0, "R7");
        f_cts = 1'b0;
        // R9: simultaneous write and read at the high level
        for (int i = 0; i < 4; i++) begin
            seq++; cyc(1'b1, 8'(seq), 1'b1, 1'b0, "R9");
        end
        // R5: drain across the low mark
        for (int i = 0; i < 115; i++) rd("R5");
        cyc(1'b0, 8'h0, 1'b0, 1'b0, "R5");
        // R9: simultaneous traffic just below the high mark
        for (int i = 0; i < 111; i++) wr("R9");
        for (int i = 0; i < 3; i++) begin
            seq++; cyc(1'b1, 8'(seq), 1'b1, 1'b0, "R9");
        end
        wr("R4"); cyc(1'b0, 8'h0, 1'b0, 1'b0, "R4");

        // R8: fill to 255, drop extra writes, clear with set winning
        while (mq.size() < 255) wr("R8");
        wr("R8"); wr("R8");
        cyc(1'b0, 8'h0, 1'b0, 1'b1, "R8");
        wr("R8");
        seq++; cyc(1'b1, 8'(seq), 1'b0, 1'b1, "R8");
        cyc(1'b0, 8'h0, 1'b0, 1'b0, "R8");
        cyc(1'b0, 8'h0, 1'b0, 1'b1, "R8");
        cyc(1'b0, 8'h0, 1'b0, 1'b0, "R8");

        // R6: forced hold through a full drain (R2 wrap checked by data)
        f_force = 1'b1;
        while (mq.size() > 0) rd("R6");
        rd("R6"); cyc(1'b0, 8'h0, 1'b0, 1'b0, "R6");
        f_force = 1'b0;
        cyc(1'b0, 8'h0, 1'b0, 1'b0, "R6");
        rd("R6");
        wr("R5"); rd("R5"); cyc(1'b0, 8'h0, 1'b0, 1'b0, "R5");
        // R6: force raises the stop request from idle
        f_force = 1'b1; cyc(1'b0, 8'h0, 1'b0, 1'b0, "R6");
        f_force = 1'b0; cyc(1'b0, 8'h0, 1'b0, 1'b0, "R6");
        f_cts = 1'b1; cyc(1'b0, 8'h0, 1'b0, 1'b0, "R7");
        cyc(1'b0, 8'h0, 1'b0, 1'b0, "R7");

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule